// File: doc/BRIEF.md
# Protection Region Configuration Register File

This block holds the settings of a set of memory protection regions and hands them to an access checker in parallel. Software never addresses a region directly. It goes through a small window of shared registers: a selector that names the current region, a base register and an attribute register that act on whichever region is selected, a global control register, and a read-only identity register. Each region therefore keeps its own copy of base and attributes, and programming one region leaves every other region untouched.

A base write can also pick the region itself. When the write carries a set select flag, its low bits load the selector in the same write, so no separate selector write is needed. The base and attribute registers also appear at three further address pairs, laid out as base, attribute, base, attribute. A single multi-word store across that address range can therefore program several regions in one burst. The host bus is a plain 32-bit register port with zero-latency reads.

Top module: `prot_region_regfile`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, the global enable, the background enable, every region enable and the selector are 0.
- R2: A read of byte offset 0x00 returns the number of implemented regions in bits [15:8] and 0 in every other bit. A write to that offset changes nothing.
- R3: Offset 0x04 is control. Bit 0 is the global enable and bit 1 is the background-region enable. A write shows on `mpu_en_o` and `bg_en_o` one cycle later. A read returns these two bits, and every other bit reads as 0.
- R4: Offset 0x08 is the selector. A write keeps the low log2(NUM_REGIONS) bits of the data, and a read returns them zero-extended.
- R5: A base write (offset 0x0C) with bit 4 clear stores data bits [31:5] as the base of the selected region. The selector and all other regions are left unchanged.
- R6: A base write with bit 4 set loads data bits [3:0] into the selector and stores bits [31:5] into that newly selected region, both within the same write.
- R7: Offsets 0x14, 0x1C and 0x24 behave exactly as the base register, and 0x18, 0x20 and 0x28 behave exactly as the attribute register, for both reads and writes.
- R8: An attribute write (offset 0x10) goes to the region named by the selector. The fields are: enable bit 0, size bits [5:1], B bit 8, C bit 9, S bit 10, TEX bits [13:11], access permission bits [18:16] and execute-never bit 20. A read returns these fields, with every other bit reading as 0.
- R9: A base read returns the selected region's stored bits [31:5], 0 in bit 4 and the selector in bits [3:0].
- R10: Region numbers at or above NUM_REGIONS, whether written to the selector or through a base write with bit 4 set, wrap to their low log2(NUM_REGIONS) bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mpu_en_o | output | 1 | Global protection enable |
| bg_en_o | output | 1 | Background-region enable |
| region_en_o | output | NUM_REGIONS | Per-region enable |
| region_base_o | output | NUM_REGIONS*27 | Per-region base bits [31:5], region i at [i*27 +: 27] |
| region_size_o | output | NUM_REGIONS*5 | Per-region size code |
| region_ap_o | output | NUM_REGIONS*3 | Per-region access permission |
| region_xn_o | output | NUM_REGIONS | Per-region execute-never |
| region_mtype_o | output | NUM_REGIONS*6 | Per-region {TEX, S, C, B} |

## Verification
Reads are combinational, so read data is due in the cycle the address is presented. The bench drives the address at a falling edge and samples shortly after it. A write becomes visible on the region, control and selector state one rising edge after the strobe. The bench therefore drives every write at a falling edge, holds it through one rising edge, and inspects the outputs or reads back at the following falling edge. A burst through the alias pairs is checked the same way: each base write moves the selector on its own edge, so the attribute write that follows lands in that region.

// File: rtl/prot_region_pkg.sv
package prot_region_pkg;

  localparam int unsigned BASE_LSB  = 5;
  localparam int unsigned BASE_W    = 32 - BASE_LSB;
  localparam int unsigned VALID_BIT = 4;
  localparam int unsigned RNUM_W    = 4;

  typedef struct packed {
    logic       xn;
    logic [2:0] ap;
    logic [2:0] tex;
    logic       s;
    logic       c;
    logic       b;
    logic [4:0] size;
    logic       en;
  } attr_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TYPE,
    SEL_CTRL,
    SEL_NUM,
    SEL_BASE,
    SEL_ATTR
  } sel_e;

  function automatic attr_t attr_unpack(input logic [31:0] w);
    attr_t a;
    a.en   = w[0];
    a.size = w[5:1];
    a.b    = w[8];
    a.c    = w[9];
    a.s    = w[10];
    a.tex  = w[13:11];
    a.ap   = w[18:16];
    a.xn   = w[20];
    return a;
  endfunction

  function automatic logic [31:0] attr_pack(input attr_t a);
    logic [31:0] w;
    w        = '0;
    w[0]     = a.en;
    w[5:1]   = a.size;
    w[8]     = a.b;
    w[9]     = a.c;
    w[10]    = a.s;
    w[13:11] = a.tex;
    w[18:16] = a.ap;
    w[20]    = a.xn;
    return w;
  endfunction

endpackage

// File: rtl/prot_bus_decode.sv
module prot_bus_decode
  import prot_region_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned ALIASES = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output sel_e              sel,
  output logic              wr_ctrl,
  output logic              wr_num,
  output logic              wr_base,
  output logic              wr_attr
);

  localparam int unsigned WIDX_W    = ADDR_W - 2;
  localparam int unsigned FIRST_WIN = 3;
  localparam int unsigned LAST_WIN  = FIRST_WIN + 1 + 2 * ALIASES;

  logic [WIDX_W-1:0] widx;

  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (int'(widx) == 0)      sel = SEL_TYPE;
    else if (int'(widx) == 1) sel = SEL_CTRL;
    else if (int'(widx) == 2) sel = SEL_NUM;
    else if (int'(widx) >= int'(FIRST_WIN) && int'(widx) <= int'(LAST_WIN)) begin
      // window pairs start on an odd word: odd = base, even = attribute
      sel = widx[0] ? SEL_BASE : SEL_ATTR;
    end
  end

  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign wr_num  = wr_en && (sel == SEL_NUM);
  assign wr_base = wr_en && (sel == SEL_BASE);
  assign wr_attr = wr_en && (sel == SEL_ATTR);

endmodule

// File: rtl/prot_select_ctrl.sv
module prot_select_ctrl
  import prot_region_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_num,
  input  logic             wr_base,
  input  logic [31:0]      wdata,
  output logic [IDX_W-1:0] cur_num,
  output logic [IDX_W-1:0] tgt_num,
  output logic             mpu_en,
  output logic             bg_en
);

  logic [IDX_W-1:0] num_q, num_d;
  logic             mpu_en_q, mpu_en_d;
  logic             bg_en_q, bg_en_d;
  logic             num_ce, ctrl_ce;
  logic             base_sets_num;

  assign base_sets_num = wr_base && wdata[VALID_BIT];

  always_comb begin
    num_ce = wr_num || base_sets_num;
    num_d  = wdata[IDX_W-1:0];
    ctrl_ce  = wr_ctrl;
    mpu_en_d = wdata[0];
    bg_en_d  = wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q    <= '0;
      mpu_en_q <= 1'b0;
      bg_en_q  <= 1'b0;
    end else begin
      if (num_ce) num_q <= num_d;
      if (ctrl_ce) begin
        mpu_en_q <= mpu_en_d;
        bg_en_q  <= bg_en_d;
      end
    end
  end

  assign cur_num = num_q;
  assign tgt_num = base_sets_num ? wdata[IDX_W-1:0] : num_q;
  assign mpu_en  = mpu_en_q;
  assign bg_en   = bg_en_q;

endmodule

// File: rtl/prot_region_slot.sv
module prot_region_slot
  import prot_region_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_base,
  input  logic              we_attr,
  input  logic [BASE_W-1:0] base_d,
  input  attr_t             attr_d,
  output logic [BASE_W-1:0] base_q,
  output attr_t             attr_q
);

  logic [BASE_W-1:0] base_r, base_nx;
  attr_t             attr_r, attr_nx;

  always_comb begin
    base_nx = we_base ? base_d : base_r;
    attr_nx = we_attr ? attr_d : attr_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_r <= '0;
      attr_r <= '0;
    end else begin
      base_r <= base_nx;
      attr_r <= attr_nx;
    end
  end

  assign base_q = base_r;
  assign attr_q = attr_r;

endmodule

// File: rtl/prot_region_regfile.sv
module prot_region_regfile
  import prot_region_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned ALIASES     = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr_en,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic                          mpu_en_o,
  output logic                          bg_en_o,
  output logic [NUM_REGIONS-1:0]        region_en_o,
  output logic [NUM_REGIONS*BASE_W-1:0] region_base_o,
  output logic [NUM_REGIONS*5-1:0]      region_size_o,
  output logic [NUM_REGIONS*3-1:0]      region_ap_o,
  output logic [NUM_REGIONS-1:0]        region_xn_o,
  output logic [NUM_REGIONS*6-1:0]      region_mtype_o
);

  localparam int unsigned IDX_W    = $clog2(NUM_REGIONS);
  localparam int unsigned TYPE_LSB = 8;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  sel_e             rd_sel;
  logic             wr_ctrl, wr_num, wr_base, wr_attr;
  logic [IDX_W-1:0] cur_num, tgt_num;
  logic             mpu_en, bg_en;
  attr_t            attr_wr;
  logic [BASE_W-1:0] slot_base [NUM_REGIONS];
  attr_t             slot_attr [NUM_REGIONS];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  prot_bus_decode #(
    .ADDR_W (ADDR_W),
    .ALIASES(ALIASES)
  ) u_decode (
    .addr   (bus_addr),
    .wr_en  (bus_wr_en),
    .sel    (rd_sel),
    .wr_ctrl(wr_ctrl),
    .wr_num (wr_num),
    .wr_base(wr_base),
    .wr_attr(wr_attr)
  );

  prot_select_ctrl #(
    .IDX_W(IDX_W)
  ) u_select (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_ctrl(wr_ctrl),
    .wr_num (wr_num),
    .wr_base(wr_base),
    .wdata  (bus_wdata),
    .cur_num(cur_num),
    .tgt_num(tgt_num),
    .mpu_en (mpu_en),
    .bg_en  (bg_en)
  );

  assign attr_wr = attr_unpack(bus_wdata);

  for (genvar g = 0; g < int'(NUM_REGIONS); g++) begin : g_slot
    logic we_base_g, we_attr_g;
    assign we_base_g = wr_base && (tgt_num == IDX_W'(g));
    assign we_attr_g = wr_attr && (cur_num == IDX_W'(g));

    prot_region_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .we_base(we_base_g),
      .we_attr(we_attr_g),
      .base_d (bus_wdata[31:BASE_LSB]),
      .attr_d (attr_wr),
      .base_q (slot_base[g]),
      .attr_q (slot_attr[g])
    );

    assign region_en_o[g]                 = slot_attr[g].en;
    assign region_base_o[g*BASE_W +: BASE_W] = slot_base[g];
    assign region_size_o[g*5 +: 5]        = slot_attr[g].size;
    assign region_ap_o[g*3 +: 3]          = slot_attr[g].ap;
    assign region_xn_o[g]                 = slot_attr[g].xn;
    assign region_mtype_o[g*6 +: 6]       = {slot_attr[g].tex, slot_attr[g].s,
                                             slot_attr[g].c, slot_attr[g].b};
  end

  always_comb begin
    bus_rdata = '0;
    case (rd_sel)
      SEL_TYPE: bus_rdata = 32'(NUM_REGIONS) << TYPE_LSB;
      SEL_CTRL: bus_rdata = {30'b0, bg_en, mpu_en};
      SEL_NUM:  bus_rdata = 32'(cur_num);
      SEL_BASE: bus_rdata = {slot_base[cur_num], 1'b0, RNUM_W'(cur_num)};
      SEL_ATTR: bus_rdata = attr_pack(slot_attr[cur_num]);
      default:  bus_rdata = '0;
    endcase
  end

  assign mpu_en_o = mpu_en;
  assign bg_en_o  = bg_en;

endmodule

// File: rtl/prot_region_regfile_chk.sv
module prot_region_regfile_chk
  import prot_region_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned IDX_W       = 3
) (
  input logic                          clk,
  input logic                          rst_int_n,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_wdata,
  input logic [31:0]                   bus_rdata,
  input logic                          wr_ctrl,
  input logic                          wr_num,
  input logic                          wr_base,
  input logic                          wr_attr,
  input logic [IDX_W-1:0]              cur_num,
  input logic                          mpu_en_o,
  input logic                          bg_en_o,
  input logic [NUM_REGIONS-1:0]        region_en_o,
  input logic [NUM_REGIONS*BASE_W-1:0] region_base_o,
  input logic [NUM_REGIONS*5-1:0]      region_size_o,
  input logic [NUM_REGIONS-1:0]        region_xn_o
);

  logic              seen_edge;
  logic              base_pend_q, attr_pend_q;
  logic [IDX_W-1:0]  base_tgt_q, attr_tgt_q;
  logic [BASE_W-1:0] base_val_q;
  logic [4:0]        size_val_q;
  logic              en_val_q, xn_val_q;

  always_ff @(posedge clk) seen_edge <= 1'b1;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      base_pend_q <= 1'b0;
      attr_pend_q <= 1'b0;
      base_tgt_q  <= '0;
      attr_tgt_q  <= '0;
      base_val_q  <= '0;
      size_val_q  <= '0;
      en_val_q    <= 1'b0;
      xn_val_q    <= 1'b0;
    end else begin
      base_pend_q <= wr_base;
      attr_pend_q <= wr_attr;
      base_tgt_q  <= bus_wdata[VALID_BIT] ? bus_wdata[IDX_W-1:0] : cur_num;
      attr_tgt_q  <= cur_num;
      base_val_q  <= bus_wdata[31:BASE_LSB];
      size_val_q  <= bus_wdata[5:1];
      en_val_q    <= bus_wdata[0];
      xn_val_q    <= bus_wdata[20];
    end
  end

  // R1: state held clear while internal reset is low
  always @(negedge clk) begin
    if (seen_edge === 1'b1 && rst_int_n === 1'b0) begin
      assert_reset_clears_R1: assert (region_en_o == '0 && !mpu_en_o && !bg_en_o && cur_num == '0);
    end
  end

  assert_type_read_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr[ADDR_W-1:2] == '0) |-> (bus_rdata == (32'(NUM_REGIONS) << 8)));

  assert_ctrl_update_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_ctrl |=> (mpu_en_o == $past(bus_wdata[0]) && bg_en_o == $past(bus_wdata[1])));

  assert_num_write_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_num |=> (cur_num == $past(bus_wdata[IDX_W-1:0])));

  assert_num_kept_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_base && !bus_wdata[VALID_BIT]) |=> $stable(cur_num));

  assert_base_lands_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    base_pend_q |-> (region_base_o[base_tgt_q*BASE_W +: BASE_W] == base_val_q));

  assert_num_from_valid_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_base && bus_wdata[VALID_BIT]) |=> (cur_num == $past(bus_wdata[IDX_W-1:0])));

  assert_attr_lands_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    attr_pend_q |-> (region_en_o[attr_tgt_q] == en_val_q &&
                     region_xn_o[attr_tgt_q] == xn_val_q &&
                     region_size_o[attr_tgt_q*5 +: 5] == size_val_q));

  assert_base_read_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (int'(bus_addr[ADDR_W-1:2]) == 3) |-> (bus_rdata[VALID_BIT] == 1'b0 &&
                                            bus_rdata[3:0] == 4'(cur_num)));

endmodule

bind prot_region_regfile prot_region_regfile_chk #(
  .NUM_REGIONS(NUM_REGIONS),
  .ADDR_W     (ADDR_W),
  .IDX_W      (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .wr_ctrl      (wr_ctrl),
  .wr_num       (wr_num),
  .wr_base      (wr_base),
  .wr_attr      (wr_attr),
  .cur_num      (cur_num),
  .mpu_en_o     (mpu_en_o),
  .bg_en_o      (bg_en_o),
  .region_en_o  (region_en_o),
  .region_base_o(region_base_o),
  .region_size_o(region_size_o),
  .region_xn_o  (region_xn_o)
);

// File: tb/prot_region_regfile_test.sv
module prot_region_regfile_test;

  localparam int N  = 8;
  localparam int AW = 8;
  localparam int BW = 27;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_wr_en;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          mpu_en_o, bg_en_o;
  logic [N-1:0]  region_en_o;
  logic [N*BW-1:0] region_base_o;
  logic [N*5-1:0]  region_size_o;
  logic [N*3-1:0]  region_ap_o;
  logic [N-1:0]    region_xn_o;
  logic [N*6-1:0]  region_mtype_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  prot_region_regfile #(.NUM_REGIONS(N), .ADDR_W(AW), .ALIASES(3)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mpu_en_o(mpu_en_o),
    .bg_en_o(bg_en_o), .region_en_o(region_en_o), .region_base_o(region_base_o),
    .region_size_o(region_size_o), .region_ap_o(region_ap_o),
    .region_xn_o(region_xn_o), .region_mtype_o(region_mtype_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] base_of(input int i);
    return 32'(region_base_o[i*BW +: BW]);
  endfunction

  task automatic t_reset();
    logic [31:0] r;
    check("R1 enables during reset", {mpu_en_o, bg_en_o, 22'b0, region_en_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 region enables after release", 32'(region_en_o), 32'h0);
    bus_read(8'h04, r); check("R1 control reads 0", r, 32'h0);
    bus_read(8'h08, r); check("R1 selector reads 0", r, 32'h0);
  endtask

  task automatic t_type();
    logic [31:0] r;
    bus_read(8'h00, r); check("R2 type value", r, 32'h0000_0800);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, r); check("R2 type after write", r, 32'h0000_0800);
    check("R2 write had no effect on control", {30'b0, bg_en_o, mpu_en_o}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] r;
    bus_write(8'h04, 32'h0000_0003);
    check("R3 both enables", {30'b0, bg_en_o, mpu_en_o}, 32'h3);
    bus_read(8'h04, r); check("R3 readback", r, 32'h3);
    bus_write(8'h04, 32'hFFFF_FFFC);
    check("R3 cleared, upper bits dropped", {30'b0, bg_en_o, mpu_en_o}, 32'h0);
    bus_read(8'h04, r); check("R3 readback zero", r, 32'h0);
    bus_write(8'h04, 32'h0000_0002);
    check("R3 background only", {30'b0, bg_en_o, mpu_en_o}, 32'h2);
  endtask

  task automatic t_number();
    logic [31:0] r;
    bus_write(8'h08, 32'h0000_0005);
    bus_read(8'h08, r); check("R4 selector 5", r, 32'h5);
    bus_write(8'h08, 32'hFFFF_FFF3);
    bus_read(8'h08, r); check("R10 selector masked 0xF3", r, 32'h3);
  endtask

  task automatic t_base_plain();
    logic [31:0] r;
    bus_write(8'h08, 32'h0000_0002);
    bus_write(8'h0C, 32'h2000_0040);
    check("R5 region 2 base", base_of(2), 32'h2000_0040 >> 5);
    check("R5 region 3 untouched", base_of(3), 32'h0);
    bus_read(8'h08, r); check("R5 selector unchanged", r, 32'h2);
    bus_read(8'h0C, r); check("R9 base readback", r, 32'h2000_0042);
  endtask

  task automatic t_base_valid();
    logic [31:0] r;
    bus_write(8'h0C, 32'h3000_0016);
    bus_read(8'h08, r); check("R6 selector from base write", r, 32'h6);
    check("R6 region 6 base", base_of(6), 32'h3000_0000 >> 5);
    check("R6 region 2 kept", base_of(2), 32'h2000_0040 >> 5);
    bus_read(8'h0C, r); check("R9 valid reads 0", r, 32'h3000_0006);
    bus_write(8'h0C, 32'h4000_0019);
    bus_read(8'h08, r); check("R10 region 9 wraps to 1", r, 32'h1);
    check("R10 region 1 base", base_of(1), 32'h4000_0000 >> 5);
  endtask

  task automatic t_alias_burst();
    logic [31:0] r;
    bus_write(8'h0C, 32'h1000_0010);
    bus_write(8'h10, 32'h0000_0003);
    bus_write(8'h14, 32'h1100_0013);
    bus_write(8'h18, 32'h0001_0005);
    bus_write(8'h1C, 32'h1200_0014);
    bus_write(8'h20, 32'h0010_0001);
    bus_write(8'h24, 32'h1300_0017);
    bus_write(8'h28, 32'h0000_0009);
    check("R7 enables after burst", 32'(region_en_o), 32'h0000_0099);
    check("R7 region 3 base", base_of(3), 32'h1100_0000 >> 5);
    check("R7 region 4 base", base_of(4), 32'h1200_0000 >> 5);
    check("R7 region 7 base", base_of(7), 32'h1300_0000 >> 5);
    check("R7 region 3 ap", 32'(region_ap_o[3*3 +: 3]), 32'h1);
    check("R7 region 4 xn", 32'(region_xn_o[4]), 32'h1);
    check("R7 region 7 size", 32'(region_size_o[7*5 +: 5]), 32'h4);
    bus_read(8'h1C, r); check("R7 alias base read", r, 32'h1300_0007);
    bus_read(8'h20, r); check("R7 alias attr read", r, 32'h0000_0009);
  endtask

  task automatic t_attr_fields();
    logic [31:0] r;
    bus_write(8'h08, 32'h0000_0005);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, r); check("R8 full readback", r, 32'h0017_3F3F);
    check("R8 enable", 32'(region_en_o[5]), 32'h1);
    check("R8 size", 32'(region_size_o[5*5 +: 5]), 32'h1F);
    check("R8 ap", 32'(region_ap_o[5*3 +: 3]), 32'h7);
    check("R8 mtype", 32'(region_mtype_o[5*6 +: 6]), 32'h3F);
    bus_write(8'h10, 32'h0010_5A0A);
    bus_read(8'h10, r); check("R8 pattern readback", r, 32'h0010_1A0A);
    check("R8 enable cleared", 32'(region_en_o[5]), 32'h0);
    check("R8 size 5", 32'(region_size_o[5*5 +: 5]), 32'h5);
    check("R8 ap 0", 32'(region_ap_o[5*3 +: 3]), 32'h0);
    check("R8 xn", 32'(region_xn_o[5]), 32'h1);
    check("R8 mtype tex3 c", 32'(region_mtype_o[5*6 +: 6]), 32'h1A);
    check("R8 other region kept", 32'(region_en_o), 32'h0000_0099);
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wr_en = 1'b0;
    bus_wdata = '0;
    repeat (4) @(negedge clk);
    t_reset();
    t_type();
    t_ctrl();
    t_number();
    t_base_plain();
    t_base_valid();
    t_alias_burst();
    t_attr_fields();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule